// File: doc/BRIEF.md
# Interleaved Line Refill Controller

This block sits between a cache and four one-word-wide memory banks. It moves a whole 4-word cache line per request. Word i of every line is stored in bank i, and all four banks share the same row, which is the line address. A request is taken from the requester when `busy` is low. The controller then spends one bus cycle sending the address. In the default interleaved mode it starts all four bank accesses at once. Once the common access latency has elapsed, it returns the words one per cycle over a single word-wide bus.

A whole-line write-back uses the same cost structure. After the address cycle, the controller takes one data word per cycle from the requester, pulsing `wr_take` for each. The bank accesses begin once the last word is held. Each bank is a fixed-latency array; the model has no row/column command sequencing and no refresh.

Setting the `INTERLEAVED` parameter to 0 gives the serial organisation used for comparison. In that mode each word runs its own bank access and its own transfer, one after the other. A line then costs 65 bus cycles instead of 20 with the default latency of 15.

Top module: `iml_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `rd_valid`, `done` and `wr_take` are all low.
- R2: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. `busy` is high in the following cycle.
- R3: A request presented while `busy` is high has no effect. The timing and data of the transfer in flight are unchanged, no further transfer starts once it ends, and the line it named keeps its contents.
- R4: In interleaved mode, counting the cycle right after the accepting edge as cycle 1, a read presents word i in cycle 17+i (for a 15-cycle access). All four banks start together, and `busy` is high for cycles 1 to 20 only.
- R5: Read words come out in order 0,1,2,3, and word i is the value last written as word i of that line.
- R6: `done` pulses once per transfer: on a read together with word 3, and always in the last busy cycle.
- R7: In interleaved mode, a write raises `wr_take` in cycles 2 to 5. The word on `wr_data` in the j-th such cycle (j = 0..3) becomes word j of the line.
- R8: In interleaved mode, a write keeps `busy` high for cycles 1 to 20, with `done` in cycle 20.
- R9: In serial mode, a read presents word i in cycle 17+16i, and `busy` is high for cycles 1 to 65.
- R10: In serial mode, a write raises `wr_take` in cycle 2+16i for word i, and `busy` is high for cycles 1 to 65 with `done` in cycle 65.
- R11: `rd_valid` is never high during a write, and `wr_take` is never high during a read.
- R12: Writing one line leaves every other line's words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when `busy` is low |
| req_write | input | 1 | 1 = line write-back, 0 = line read |
| req_line | input | LINE_W | Line address (bank row) |
| wr_data | input | WORD_W | Write word, taken at the end of each `wr_take` cycle |
| wr_take | output | 1 | Controller consumes `wr_data` this cycle |
| busy | output | 1 | Transfer in progress; requests ignored |
| rd_valid | output | 1 | `rd_data` holds a read word this cycle |
| rd_data | output | WORD_W | Read word, zero when `rd_valid` is low |
| done | output | 1 | Last cycle of the transfer |

## Verification
The bench runs an interleaved and a serial instance side by side on the same request stream. It checks every output on every cycle of each transfer against a cycle position worked out from the address, access and transfer costs. A controller that overlapped accesses in serial mode, or serialised them in interleaved mode, would put `rd_valid`, `wr_take` or the fall of `busy` in the wrong cycle. Stray requests are injected mid-transfer, including a write aimed at a line that is read afterwards. A design that accepted them would stretch `busy` or corrupt that line. Lines are rewritten and their neighbours re-read, so swapped word order, a wrong bank select, or a write that spills into another row shows up as a data mismatch.

// File: rtl/iml_pkg.sv
package iml_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WCAP,
    ST_ACC,
    ST_XFER
  } iml_state_e;

  // Busy cycles for one line, address cycle included.
  function automatic int unsigned line_cycles(bit ilv, int unsigned words, int unsigned lat);
    if (ilv) return 1 + lat + words;
    return 1 + words * (lat + 1);
  endfunction

  // Cycle (1 = first cycle after acceptance) in which read word idx appears.
  function automatic int unsigned read_slot(bit ilv, int unsigned idx, int unsigned lat);
    if (ilv) return lat + 2 + idx;
    return lat + 2 + idx * (lat + 1);
  endfunction

endpackage

// File: rtl/iml_bank.sv
module iml_bank #(
  parameter int WORD_W     = 32,
  parameter int ROW_W      = 6,
  parameter int ACCESS_LAT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              ack
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(ACCESS_LAT + 1);

  logic [WORD_W-1:0] mem [ROWS];
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  row_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q;

  // Last cycle of the fixed-latency access.
  assign ack   = active && (cnt == CNT_W'(ACCESS_LAT - 1));
  assign rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      row_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      active  <= 1'b1;
      cnt     <= '0;
      row_q   <= row;
      we_q    <= we;
      wdata_q <= wdata;
    end else if (active) begin
      if (ack) active <= 1'b0;
      else     cnt    <= cnt + 1'b1;
    end
  end

  // Array port: read captured at start, write committed when the access ends.
  always_ff @(posedge clk) begin
    if (start && !we) rdata_q <= mem[row];
    if (ack && we_q)  mem[row_q] <= wdata_q;
  end

endmodule

// File: rtl/iml_seq.sv
module iml_seq
  import iml_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int LINE_W      = 6,
  parameter int IDX_W       = 2,
  parameter int INTERLEAVED = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [LINE_W-1:0]    req_line,
  input  logic [NUM_BANKS-1:0] bank_ack,
  output logic                 busy,
  output logic                 wr_mode,
  output logic [LINE_W-1:0]    cur_line,
  output logic [IDX_W-1:0]     word_idx,
  output logic [NUM_BANKS-1:0] bank_start,
  output logic                 rd_valid,
  output logic                 wr_take,
  output logic                 done
);
  localparam bit IS_ILV = (INTERLEAVED != 0);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

  iml_state_e        st, st_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic              wr_q;
  logic [LINE_W-1:0] line_q;
  logic              accept;
  logic              start_evt;
  logic              acc_ack;
  logic              last;
  logic [IDX_W-1:0]  start_sel;

  assign last = (idx == LAST_IDX);

  // Bank that ends the current access, and bank(s) a start event hits.
  assign start_sel = (st == ST_XFER) ? idx + 1'b1 : idx;

  generate
    if (IS_ILV) begin : g_par
      assign acc_ack    = bank_ack[0];
      assign bank_start = {NUM_BANKS{start_evt}};
    end else begin : g_ser
      assign acc_ack = bank_ack[idx];
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign bank_start[b] = start_evt && (start_sel == IDX_W'(b));
      end
    end
  endgenerate

  always_comb begin
    st_n      = st;
    idx_n     = idx;
    accept    = 1'b0;
    start_evt = 1'b0;
    wr_take   = 1'b0;
    rd_valid  = 1'b0;
    done      = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          idx_n  = '0;
          st_n   = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (wr_q) begin
          st_n = ST_WCAP;
        end else begin
          start_evt = 1'b1;
          st_n      = ST_ACC;
        end
      end
      ST_WCAP: begin
        wr_take = 1'b1;
        if (IS_ILV) begin
          if (last) begin
            start_evt = 1'b1;
            st_n      = ST_ACC;
          end else begin
            idx_n = idx + 1'b1;
          end
        end else begin
          start_evt = 1'b1;
          st_n      = ST_ACC;
        end
      end
      ST_ACC: begin
        if (acc_ack) begin
          if (!wr_q) begin
            st_n = ST_XFER;
          end else if (IS_ILV || last) begin
            done = 1'b1;
            st_n = ST_IDLE;
          end else begin
            idx_n = idx + 1'b1;
            st_n  = ST_WCAP;
          end
        end
      end
      ST_XFER: begin
        rd_valid = 1'b1;
        if (last) begin
          done = 1'b1;
          st_n = ST_IDLE;
        end else begin
          idx_n = idx + 1'b1;
          if (!IS_ILV) begin
            start_evt = 1'b1;
            st_n      = ST_ACC;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      wr_q   <= 1'b0;
      line_q <= '0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
      if (accept) begin
        wr_q   <= req_write;
        line_q <= req_line;
      end
    end
  end

  assign busy     = (st != ST_IDLE);
  assign wr_mode  = wr_q;
  assign cur_line = line_q;
  assign word_idx = idx;

endmodule

// File: rtl/iml_lanes.sv
module iml_lanes #(
  parameter int NUM_BANKS   = 4,
  parameter int WORD_W      = 32,
  parameter int IDX_W       = 2,
  parameter int INTERLEAVED = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_take,
  input  logic                              rd_valid,
  input  logic [IDX_W-1:0]                  word_idx,
  input  logic [WORD_W-1:0]                 wr_data,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_rdata,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_wdata,
  output logic [WORD_W-1:0]                 rd_data
);
  // Interleaved writes park words 0..N-2 until the last word arrives;
  // the final word and every serial word go straight to the bank.
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
      if ((INTERLEAVED != 0) && (b < NUM_BANKS - 1)) begin : g_hold
        logic [WORD_W-1:0] hold_q;
        always_ff @(posedge clk) begin
          if (!rst_n)                                  hold_q <= '0;
          else if (wr_take && (word_idx == IDX_W'(b))) hold_q <= wr_data;
        end
        assign bank_wdata[b] = hold_q;
      end else begin : g_pass
        assign bank_wdata[b] = wr_data;
      end
    end
  endgenerate

  assign rd_data = rd_valid ? bank_rdata[word_idx] : '0;

endmodule

// File: rtl/iml_ctrl.sv
module iml_ctrl #(
  parameter int WORD_W      = 32,
  parameter int LINE_W      = 6,
  parameter int NUM_BANKS   = 4,
  parameter int ACCESS_LAT  = 15,
  parameter int INTERLEAVED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_line,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_take,
  output logic              busy,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              done
);
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  // Named internal events, also observed by the bound checker.
  logic                             wr_mode;
  logic [LINE_W-1:0]                cur_line;
  logic [IDX_W-1:0]                 word_idx;
  logic [NUM_BANKS-1:0]             bank_start;
  logic [NUM_BANKS-1:0]             bank_ack;
  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_rdata;
  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_wdata;

  iml_seq #(
    .NUM_BANKS  (NUM_BANKS),
    .LINE_W     (LINE_W),
    .IDX_W      (IDX_W),
    .INTERLEAVED(INTERLEAVED)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_line  (req_line),
    .bank_ack  (bank_ack),
    .busy      (busy),
    .wr_mode   (wr_mode),
    .cur_line  (cur_line),
    .word_idx  (word_idx),
    .bank_start(bank_start),
    .rd_valid  (rd_valid),
    .wr_take   (wr_take),
    .done      (done)
  );

  iml_lanes #(
    .NUM_BANKS  (NUM_BANKS),
    .WORD_W     (WORD_W),
    .IDX_W      (IDX_W),
    .INTERLEAVED(INTERLEAVED)
  ) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_take   (wr_take),
    .rd_valid  (rd_valid),
    .word_idx  (word_idx),
    .wr_data   (wr_data),
    .bank_rdata(bank_rdata),
    .bank_wdata(bank_wdata),
    .rd_data   (rd_data)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      iml_bank #(
        .WORD_W    (WORD_W),
        .ROW_W     (LINE_W),
        .ACCESS_LAT(ACCESS_LAT)
      ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .start(bank_start[b]),
        .we   (wr_mode),
        .row  (cur_line),
        .wdata(bank_wdata[b]),
        .rdata(bank_rdata[b]),
        .ack  (bank_ack[b])
      );
    end
  endgenerate

endmodule

// File: rtl/iml_checker.sv
module iml_checker
  import iml_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int LINE_W      = 6,
  parameter int ACCESS_LAT  = 15,
  parameter int INTERLEAVED = 1,
  parameter int IDX_W       = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 busy,
  input logic                 rd_valid,
  input logic                 done,
  input logic                 wr_take,
  input logic                 wr_mode,
  input logic [LINE_W-1:0]    cur_line,
  input logic [IDX_W-1:0]     word_idx,
  input logic [NUM_BANKS-1:0] bank_start,
  input logic [NUM_BANKS-1:0] bank_ack
);
  localparam bit          IS_ILV   = (INTERLEAVED != 0);
  localparam logic [15:0] LINE_LEN = 16'(line_cycles(IS_ILV, NUM_BANKS, ACCESS_LAT));

  logic [15:0]      busy_len;
  logic [15:0]      lat_cnt;
  logic [IDX_W-1:0] rd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_len <= '0;
      lat_cnt  <= '0;
      rd_seen  <= '0;
    end else begin
      busy_len <= busy ? busy_len + 16'd1 : 16'd0;
      if (bank_start[0])         lat_cnt <= '0;
      else if (lat_cnt != '1)    lat_cnt <= lat_cnt + 16'd1;
      if (!busy)                 rd_seen <= '0;
      else if (rd_valid)         rd_seen <= rd_seen + 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !rd_valid && !done && !wr_take));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_hold_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_line));

  p_line_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_len == LINE_LEN - 16'd1));

  p_bank_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ack[0] |-> (lat_cnt == 16'(ACCESS_LAT - 1)));

  p_word_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (word_idx == rd_seen));

  p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_mode) |-> (rd_valid && word_idx == IDX_W'(NUM_BANKS - 1)));

  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_take_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (wr_mode && busy));

  p_read_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !wr_mode);

  generate
    if (IS_ILV) begin : g_par_chk
      p_start_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_start) |-> (&bank_start));
    end else begin : g_ser_chk
      p_start_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_start));
    end
  endgenerate

endmodule

bind iml_ctrl iml_checker #(
  .NUM_BANKS  (NUM_BANKS),
  .LINE_W     (LINE_W),
  .ACCESS_LAT (ACCESS_LAT),
  .INTERLEAVED(INTERLEAVED),
  .IDX_W      (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .done      (done),
  .wr_take   (wr_take),
  .wr_mode   (wr_mode),
  .cur_line  (cur_line),
  .word_idx  (word_idx),
  .bank_start(bank_start),
  .bank_ack  (bank_ack)
);

// File: tb/iml_ctrl_tb.sv
module iml_ctrl_tb;
  localparam int W   = 16;
  localparam int LW  = 3;
  localparam int LAT = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [LW-1:0] req_line;
  logic [W-1:0]  wd_a, wd_b;
  logic          take_a, busy_a, rv_a, done_a;
  logic          take_b, busy_b, rv_b, done_b;
  logic [W-1:0]  rd_a, rd_b;

  int checks = 0;
  int errors = 0;
  int gen_ctr = 0;
  int gen_mem [8];

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  iml_ctrl #(.WORD_W(W), .LINE_W(LW), .NUM_BANKS(4), .ACCESS_LAT(LAT), .INTERLEAVED(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_line(req_line), .wr_data(wd_a), .wr_take(take_a), .busy(busy_a),
    .rd_valid(rv_a), .rd_data(rd_a), .done(done_a));

  iml_ctrl #(.WORD_W(W), .LINE_W(LW), .NUM_BANKS(4), .ACCESS_LAT(LAT), .INTERLEAVED(0)) u_dut_ser (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_line(req_line), .wr_data(wd_b), .wr_take(take_b), .busy(busy_b),
    .rd_valid(rv_b), .rd_data(rd_b), .done(done_b));

  function automatic logic [W-1:0] pat(int line, int i, int g);
    return W'((g << 8) ^ (line << 4) ^ i ^ 16'h5000);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected behaviour of one instance in cycle t after the accepting edge.
  task automatic check_one(bit ilv, int t, bit wr, int line, int g, bit spur, string dtag,
                           logic busy, logic rv, logic [W-1:0] rd, logic dn, logic wt);
    int total = ilv ? (1 + LAT + 4) : (1 + 4 * (LAT + 1));
    int step  = ilv ? 1 : LAT + 1;
    int base  = wr ? 2 : LAT + 2;
    int widx  = -1;
    string tb_tag;
    if (t >= base && ((t - base) % step) == 0 && ((t - base) / step) < 4)
      widx = (t - base) / step;
    if (t == 1)               tb_tag = "R2";
    else if (t > total && spur) tb_tag = "R3";
    else if (wr)              tb_tag = ilv ? "R8" : "R10";
    else                      tb_tag = ilv ? "R4" : "R9";
    chk(tb_tag, ilv ? "busy(par)" : "busy(ser)", 32'(busy), 32'(t <= total));
    chk(wr ? "R11" : (ilv ? "R4" : "R9"), "rd_valid", 32'(rv), 32'(!wr && widx >= 0));
    chk(wr ? (ilv ? "R7" : "R10") : "R11", "wr_take", 32'(wt), 32'(wr && widx >= 0));
    chk(wr ? (ilv ? "R8" : "R10") : "R6", "done", 32'(dn), 32'(t == total));
    if (!wr && widx >= 0)
      chk(dtag, $sformatf("word%0d line%0d", widx, line), 32'(rd), 32'(pat(line, widx, g)));
  endtask

  task automatic run_txn(bit wr, int line, bit spur, string dtag);
    int g  = wr ? gen_ctr + 1 : gen_mem[line];
    int ka = 0;
    int kb = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_line  = LW'(line);
    for (int t = 1; t <= 72; t++) begin
      @(negedge clk);
      if (t == 1) req_valid = 1'b0;
      if (spur && t == 5) begin  // stray request while busy, R3
        req_valid = 1'b1;
        req_write = !wr;
        req_line  = LW'(line ^ 1);
      end
      if (spur && t == 6) req_valid = 1'b0;
      check_one(1'b1, t, wr, line, g, spur, dtag, busy_a, rv_a, rd_a, done_a, take_a);
      check_one(1'b0, t, wr, line, g, spur, dtag, busy_b, rv_b, rd_b, done_b, take_b);
      if (take_a) begin wd_a = pat(line, ka, g); ka++; end
      if (take_b) begin wd_b = pat(line, kb, g); kb++; end
    end
    if (wr) begin
      gen_ctr       = g;
      gen_mem[line] = g;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_line = '0;
    wd_a = '0; wd_b = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    chk("R1", "busy", 32'(busy_a | busy_b), 32'd0);
    chk("R1", "rd_valid", 32'(rv_a | rv_b), 32'd0);
    chk("R1", "done", 32'(done_a | done_b), 32'd0);
    chk("R1", "wr_take", 32'(take_a | take_b), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", 32'(busy_a | busy_b), 32'd0);

    for (int l = 0; l < 8; l++) run_txn(1'b1, l, l == 3, "R7");
    // Read every line; a stray write to line 3 hits during the line 2 read (R3)
    for (int l = 0; l < 8; l++) run_txn(1'b0, l, l == 2, "R5");
    // Rewrite one line and re-read it and its neighbours (R12)
    run_txn(1'b1, 4, 1'b0, "R12");
    run_txn(1'b0, 4, 1'b0, "R12");
    run_txn(1'b0, 5, 1'b1, "R12");
    run_txn(1'b0, 3, 1'b0, "R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule